// File: doc/BRIEF.md
# Reset Sequencing Controller

This block runs on the always-on slow clock and drives three active-low reset outputs: one for the processor, one for the peripherals, and one for an external open-drain reset pin. It takes requests from four sources and holds each output for a controlled number of cycles. The sources are a watchdog fault, a software write to a keyed control register, a low level on the external pin that the block is not driving itself, and its own power-up release. It records the cause of the most recent sequence and flags a software-initiated sequence as busy.

A watchdog fault is honoured only while the watchdog reset-enable input is high. It keeps the internal resets low for a fixed three cycles. A mode input selects either a processor-only reset or a full reset that also pulses the external pin. The external pulse is 2^(setting+1) cycles long, where the setting is a 4-bit field in the mode register. Software chooses any mix of the three outputs with separate request bits. After the block's own pulse ends, the external pin is blanked for a short time, so that the block's own pulse and its synchronizer tail are never taken for a pushbutton reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: On release of `rst_n`, the processor and peripheral resets stay low for 3 cycles counted from the release, the external pin is released, and the status shows type 0 with busy clear.
- R2: When a watchdog fault arrives with enable high and processor-only clear, the processor and peripheral resets go low for 3 cycles and the external pin for 2^(setting+1) cycles. The status type becomes 2.
- R3: When a watchdog fault arrives with processor-only set, only the processor reset goes low, for 3 cycles. The status type becomes 2.
- R4: A watchdog fault has no effect while the enable input is low. No output moves and the status type is kept.
- R5: A control write (address 0) with key 0xA5 in bits [31:24] starts a software sequence. Bit 0 selects the processor reset, bit 1 the peripheral reset and bit 2 the external pin. Only the selected outputs go low: 3 cycles for the internal resets and 2^(setting+1) cycles for the pin. The status type becomes 3.
- R6: Status bit 0 (busy) reads 1 while a software sequence runs and 0 once it ends. Status is read at address 2, and the type is in bits [10:8].
- R7: A control write with a wrong key is ignored. Any request that arrives while a sequence is running is ignored, and the type of that sequence is kept.
- R8: A low level on the external pin while the block drives it, or during the synchronizer tail that follows, never starts a user reset.
- R9: A low level on the pin from outside, seen while idle, starts a user reset of type 4. The processor and peripheral resets stay low while the synchronized level is low and for 3 cycles after it. With a 2-stage synchronizer, a 10-cycle press gives a 12-cycle reset.
- R10: If a watchdog fault and a keyed control write arrive in the same cycle, the watchdog request wins and the write is dropped.
- R11: The mode register at address 1 reads back what was written. Its bits [3:0] set the external pulse length, so a setting of 2 gives 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| wd_fault_i | input | 1 | Watchdog fault pulse |
| wd_rst_en_i | input | 1 | Watchdog faults may reset when high |
| wd_proc_only_i | input | 1 | Watchdog resets only the processor when high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 mode |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address: 1 mode, 2 status |
| rd_data_o | output | 32 | Read data (combinational) |
| ext_line_i | input | 1 | Sensed level of the external reset pin |
| proc_rst_n_o | output | 1 | Processor reset, active low |
| periph_rst_n_o | output | 1 | Peripheral reset, active low |
| ext_drive_n_o | output | 1 | External pin pull-down, 0 pulls the pin low |

## Verification
Two requests can land in the same cycle: a watchdog fault and a keyed software write. The bench provokes this by raising the fault and the control write on the same falling edge. It judges the result by the output pulse lengths and the latched type: the processor alone is held for 3 cycles, the pin is not pulsed, and the type is 2. Requests that arrive during a running sequence are also checked, in both orders, through the same pulse counts and status reads.

// File: rtl/rsc_pkg.sv
// Shared types and constants of the reset sequencing controller.
// Assumes a single slow clock domain for all users of the package.
package rsc_pkg;
    typedef enum logic [2:0] {
        RT_POWERUP  = 3'd0,
        RT_WATCHDOG = 3'd2,
        RT_SOFTWARE = 3'd3,
        RT_USER     = 3'd4
    } rst_type_e;

    typedef struct packed {
        logic ext;
        logic periph;
        logic proc;
    } rst_sel_t;

    localparam logic [7:0] CTRL_KEY  = 8'hA5;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/rsc_regs.sv
// Register front end: holds the mode word, decodes keyed control writes
// into a software request, and muxes read data. Assumes DW >= 16.
module rsc_regs
    import rsc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [1:0]       rd_addr,
    input  logic             busy,
    input  rst_type_e        rst_type,
    output logic [DW-1:0]    rd_data,
    output logic [LEN_W-1:0] ext_len,
    output logic             sw_req,
    output rst_sel_t         sw_sel
);
    logic [DW-1:0] mode_q;

    // Mode register: written without key, reset to shortest pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en && wr_addr == ADDR_MODE) begin
            mode_q <= wr_data;
        end
    end

    assign ext_len = mode_q[LEN_W-1:0];

    // Control decode: a request needs the key and at least one select bit.
    always_comb begin
        sw_sel = rst_sel_t'(wr_data[2:0]);
        sw_req = wr_en && (wr_addr == ADDR_CTRL)
                 && (wr_data[DW-1 -: 8] == CTRL_KEY)
                 && (wr_data[2:0] != 3'b000);
    end

    // Read mux: control reads as zero, status packs busy and type.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_MODE: rd_data = mode_q;
            ADDR_STAT: begin
                rd_data[0]    = busy;
                rd_data[10:8] = rst_type;
            end
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rsc_line_mon.sv
// External pin monitor: synchronizes the pin and raises a user request
// when it is low while not driven by this block, blanked for SYNC_STAGES+1
// cycles after the block's own pulse so its tail is not mistaken.
module rsc_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic drive_active,
    output logic line_low,
    output logic user_req
);
    localparam int BW = $clog2(SYNC_STAGES + 2);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(SYNC_STAGES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [BW-1:0]          blank_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            // Single-stage capture of the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_i;
            end
        end else begin : g_syncn
            // Multi-stage shift synchronizer for the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            end
        end
    endgenerate

    // Blanking window: reloaded while driving, counts down afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)                blank_q <= '0;
        else if (drive_active)     blank_q <= BLANK_LOAD;
        else if (blank_q != '0)    blank_q <= blank_q - 1'b1;
    end

    assign line_low = !sync_q[SYNC_STAGES-1];
    assign user_req = line_low && !drive_active && (blank_q == '0);
endmodule

// File: rtl/rsc_seq.sv
// Sequencer: arbitrates requests (watchdog, software, user), latches the
// cause, and times the internal hold and the external pulse with two
// down-counters. Requests are taken only when both counters are idle.
module rsc_seq
    import rsc_pkg::*;
#(
    parameter int HOLD  = 3,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_fault,
    input  logic             wd_en,
    input  logic             wd_proc_only,
    input  logic             sw_req,
    input  rst_sel_t         sw_sel,
    input  logic             user_req,
    input  logic             line_low,
    input  logic [LEN_W-1:0] ext_len,
    output logic             proc_rst_n,
    output logic             periph_rst_n,
    output logic             ext_drive_n,
    output logic             drive_active,
    output logic             busy,
    output rst_type_e        rst_type
);
    localparam int HW    = $clog2(HOLD + 1);
    localparam int CNT_W = (1 << LEN_W) + 1;
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD);

    logic [HW-1:0]    hold_q;
    logic [CNT_W-1:0] ext_q;
    rst_sel_t         sel_q;
    rst_type_e        type_q;
    logic             active, wd_go, sw_go, usr_go;
    logic [LEN_W:0]   shamt;
    logic [CNT_W-1:0] ext_load;

    // Arbitration: watchdog over software over user, all need idle.
    always_comb begin
        active   = (hold_q != '0) || (ext_q != '0);
        wd_go    = wd_fault && wd_en && !active;
        sw_go    = sw_req && !active && !wd_go;
        usr_go   = user_req && !active && !wd_go && !sw_req;
        shamt    = {1'b0, ext_len} + (LEN_W+1)'(1);
        ext_load = CNT_W'(1) << shamt;
    end

    // Sequence registers: load on a granted request, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= HOLD_LOAD;
            ext_q  <= '0;
            sel_q  <= '{ext: 1'b0, periph: 1'b1, proc: 1'b1};
            type_q <= RT_POWERUP;
        end else if (wd_go) begin
            hold_q <= HOLD_LOAD;
            ext_q  <= wd_proc_only ? '0 : ext_load;
            sel_q  <= '{ext: !wd_proc_only, periph: !wd_proc_only, proc: 1'b1};
            type_q <= RT_WATCHDOG;
        end else if (sw_go) begin
            hold_q <= (sw_sel.proc || sw_sel.periph) ? HOLD_LOAD : '0;
            ext_q  <= sw_sel.ext ? ext_load : '0;
            sel_q  <= sw_sel;
            type_q <= RT_SOFTWARE;
        end else if (usr_go) begin
            hold_q <= HOLD_LOAD;
            ext_q  <= '0;
            sel_q  <= '{ext: 1'b0, periph: 1'b1, proc: 1'b1};
            type_q <= RT_USER;
        end else begin
            if (type_q == RT_USER && line_low && hold_q != '0)
                hold_q <= HOLD_LOAD;
            else if (hold_q != '0)
                hold_q <= hold_q - 1'b1;
            if (ext_q != '0)
                ext_q <= ext_q - 1'b1;
        end
    end

    assign proc_rst_n   = !((hold_q != '0) && sel_q.proc);
    assign periph_rst_n = !((hold_q != '0) && sel_q.periph);
    assign drive_active = (ext_q != '0);
    assign ext_drive_n  = !drive_active;
    assign busy         = active && (type_q == RT_SOFTWARE);
    assign rst_type     = type_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
// Top of the reset sequencing controller: wires register front end,
// pin monitor and sequencer. Assumes all inputs are in the slow domain
// except ext_line_i, which is synchronized inside.
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int DW          = 32,
    parameter int LEN_W       = 4,
    parameter int HOLD        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wd_fault_i,
    input  logic          wd_rst_en_i,
    input  logic          wd_proc_only_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [1:0]    rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          ext_line_i,
    output logic          proc_rst_n_o,
    output logic          periph_rst_n_o,
    output logic          ext_drive_n_o
);
    logic             busy;
    rst_type_e        rst_type;
    logic [LEN_W-1:0] ext_len;
    logic             sw_req;
    rst_sel_t         sw_sel;
    logic             line_low, user_req, drive_active;

    rsc_regs #(.DW(DW), .LEN_W(LEN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .rd_addr  (rd_addr_i),
        .busy     (busy),
        .rst_type (rst_type),
        .rd_data  (rd_data_o),
        .ext_len  (ext_len),
        .sw_req   (sw_req),
        .sw_sel   (sw_sel)
    );

    rsc_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (ext_line_i),
        .drive_active (drive_active),
        .line_low     (line_low),
        .user_req     (user_req)
    );

    rsc_seq #(.HOLD(HOLD), .LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wd_fault     (wd_fault_i),
        .wd_en        (wd_rst_en_i),
        .wd_proc_only (wd_proc_only_i),
        .sw_req       (sw_req),
        .sw_sel       (sw_sel),
        .user_req     (user_req),
        .line_low     (line_low),
        .ext_len      (ext_len),
        .proc_rst_n   (proc_rst_n_o),
        .periph_rst_n (periph_rst_n_o),
        .ext_drive_n  (ext_drive_n_o),
        .drive_active (drive_active),
        .busy         (busy),
        .rst_type     (rst_type)
    );
endmodule

// File: rtl/rsc_checker.sv
// Property checker for rst_seq_ctrl, attached by bind below.
module rsc_checker #(
    parameter int HOLD = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       proc_rst_n,
    input logic       periph_rst_n,
    input logic       ext_drive_n,
    input logic       busy,
    input logic [2:0] rst_type
);
    logic       any_on;
    logic [7:0] low_cnt;

    assign any_on = !proc_rst_n || !periph_rst_n || !ext_drive_n;

    // Run length of the processor reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            low_cnt <= '0;
        else if (proc_rst_n)   low_cnt <= '0;
        else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
    end

    // R6
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (proc_rst_n && periph_rst_n && ext_drive_n));

    // R7
    type_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_on && $past(any_on)) |-> $stable(rst_type));

    // R2
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_type != 3'd4) |-> (low_cnt <= 8'(HOLD)));

    // R8
    drive_not_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_drive_n |-> (rst_type != 3'd4));

    // R5
    known_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({proc_rst_n, periph_rst_n, ext_drive_n, busy}));
endmodule

bind rst_seq_ctrl rsc_checker #(.HOLD(HOLD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .proc_rst_n   (proc_rst_n_o),
    .periph_rst_n (periph_rst_n_o),
    .ext_drive_n  (ext_drive_n_o),
    .busy         (busy),
    .rst_type     (rst_type)
);

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wd_fault = 1'b0, wd_en = 1'b1, wd_po = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd2;
    logic [31:0] wr_data = '0, rd_data;
    logic        button_n = 1'b1;
    logic        proc_n, periph_n, ext_n, ext_line;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    assign ext_line = ext_n & button_n;

    always #10 clk = ~clk;

    rst_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wd_fault_i(wd_fault), .wd_rst_en_i(wd_en),
        .wd_proc_only_i(wd_po), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .ext_line_i(ext_line), .proc_rst_n_o(proc_n),
        .periph_rst_n_o(periph_n), .ext_drive_n_o(ext_n)
    );

    // Vector: kind[26] sel[25:23] len[22:19] po[18] proc[17:13] periph[12:8] ext[7:3] type[2:0]
    localparam logic [26:0] VEC [7] = '{
        {1'b0, 3'b000, 4'd2, 1'b0, 5'd3, 5'd3, 5'd8,  3'd2},  // R2 R11
        {1'b0, 3'b000, 4'd2, 1'b1, 5'd3, 5'd0, 5'd0,  3'd2},  // R3
        {1'b1, 3'b111, 4'd1, 1'b0, 5'd3, 5'd3, 5'd4,  3'd3},  // R5
        {1'b1, 3'b001, 4'd0, 1'b0, 5'd3, 5'd0, 5'd0,  3'd3},  // R5
        {1'b1, 3'b100, 4'd3, 1'b0, 5'd0, 5'd0, 5'd16, 3'd3},  // R5 R8
        {1'b1, 3'b010, 4'd0, 1'b0, 5'd0, 5'd3, 5'd0,  3'd3},  // R5
        {1'b0, 3'b000, 4'd0, 1'b0, 5'd3, 5'd3, 5'd2,  3'd2}   // R2
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure(output int pc, output int qc, output int ec, output bit b0);
        pc = 0; qc = 0; ec = 0; b0 = rd_data[0];
        for (int i = 0; i < 40; i++) begin
            if (!proc_n) pc++;
            if (!periph_n) qc++;
            if (!ext_n) ec++;
            @(negedge clk);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic int stat_type();
        return int'(rd_data[10:8]);
    endfunction

    initial begin
        int pc, qc, ec;
        bit b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        measure(pc, qc, ec, b0);
        check(pc == 3, "R1 proc", pc, 3);
        check(qc == 3, "R1 periph", qc, 3);
        check(ec == 0, "R1 ext", ec, 0);
        check(stat_type() == 0, "R1 type", stat_type(), 0);
        check(b0 == 1'b0, "R1 busy", int'(b0), 0);

        for (int i = 0; i < 7; i++) begin
            logic [26:0] v;
            v = VEC[i];
            write_reg(2'd1, {28'd0, v[22:19]});
            if (v[26]) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = {8'hA5, 21'd0, v[25:23]};
            end else begin
                wd_fault = 1'b1; wd_po = v[18];
            end
            @(negedge clk);
            wr_en = 1'b0; wd_fault = 1'b0;
            measure(pc, qc, ec, b0);
            check(pc == int'(v[17:13]), "R2/R3/R5 proc", pc, int'(v[17:13]));
            check(qc == int'(v[12:8]), "R2/R3/R5 periph", qc, int'(v[12:8]));
            check(ec == int'(v[7:3]), "R2/R5/R11 ext", ec, int'(v[7:3]));
            check(stat_type() == int'(v[2:0]), "R2/R5 type", stat_type(), int'(v[2:0]));
            check(b0 == v[26], "R6 busy during", int'(b0), int'(v[26]));
            check(rd_data[0] == 1'b0, "R6 busy after", int'(rd_data[0]), 0);
        end

        // R11 mode readback
        write_reg(2'd1, 32'h0000_0005);
        rd_addr = 2'd1; #1;
        check(rd_data == 32'h5, "R11 readback", int'(rd_data), 5);
        rd_addr = 2'd2;
        write_reg(2'd1, 32'h0000_0002);

        // R7 wrong key ignored
        write_reg(2'd0, 32'h5A00_0007);
        measure(pc, qc, ec, b0);
        check(pc + qc + ec == 0, "R7 bad key", pc + qc + ec, 0);
        check(stat_type() == 2, "R7 bad key type", stat_type(), 2);

        // R7 software write during watchdog sequence ignored
        wd_fault = 1'b1; wd_po = 1'b1;
        @(negedge clk);
        wd_fault = 1'b0;
        write_reg(2'd0, 32'hA500_0004);
        measure(pc, qc, ec, b0);
        check(ec == 0, "R7 write while busy ext", ec, 0);
        check(stat_type() == 2, "R7 write while busy type", stat_type(), 2);

        // R7 watchdog fault during software sequence ignored
        write_reg(2'd0, 32'hA500_0004);
        repeat (3) @(negedge clk);
        wd_fault = 1'b1; wd_po = 1'b0;
        @(negedge clk);
        wd_fault = 1'b0;
        measure(pc, qc, ec, b0);
        check(pc == 0, "R7 fault while busy proc", pc, 0);
        check(stat_type() == 3, "R7 fault while busy type", stat_type(), 3);

        // R10 same-cycle watchdog and software write
        wd_fault = 1'b1; wd_po = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'hA500_0006;
        @(negedge clk);
        wd_fault = 1'b0; wr_en = 1'b0;
        measure(pc, qc, ec, b0);
        check(pc == 3, "R10 proc", pc, 3);
        check(qc == 0, "R10 periph", qc, 0);
        check(ec == 0, "R10 ext", ec, 0);
        check(stat_type() == 2, "R10 type", stat_type(), 2);

        // R4 disabled watchdog has no effect
        wd_en = 1'b0; wd_fault = 1'b1; wd_po = 1'b0;
        @(negedge clk);
        wd_fault = 1'b0;
        measure(pc, qc, ec, b0);
        check(pc + qc + ec == 0, "R4 outputs", pc + qc + ec, 0);
        check(stat_type() == 2, "R4 type", stat_type(), 2);
        wd_en = 1'b1;

        // R9 user pushbutton reset, 10-cycle press
        pc = 0; qc = 0; ec = 0;
        button_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (i == 10) button_n = 1'b1;
            if (!proc_n) pc++;
            if (!periph_n) qc++;
            if (!ext_n) ec++;
            @(negedge clk);
        end
        check(pc == 12, "R9 proc", pc, 12);
        check(qc == 12, "R9 periph", qc, 12);
        check(ec == 0, "R9 ext", ec, 0);
        check(stat_type() == 4, "R9 type", stat_type(), 4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule